// File: doc/BRIEF.md
# Parallel Converter Result Read Interface

This block sits on the output side of a sampled data converter. Each new 16-bit result is first announced by the converter core, which pulses `announce` with the word on `resWord`. The block holds the word in a pending register for two clock cycles and then moves it into the output register. During those two cycles the active-low ready line `drdyN` is held high. When the word loads, `drdyN` falls, so the host always sees a fresh falling edge, whether or not it read the previous result.

The host reads through active-low `csN` and `rdN`. Both are level inputs that the block samples only on the rising edge of `clk`. The bus is driven for every cycle that follows an edge at which both were sampled low. While the host is reading, the output register is frozen. An update that falls due during a read waits until the read has finished.

A `flush` pulse marks a sync, reset or calibration sequence. It discards any stale or pending result, so the next result to load is the first valid result after that sequence.

The 16-bit bus is presented as a data vector plus one output enable per bit, for a pad ring to combine. Bits with the enable low are treated as high impedance.

Top module: `conv_read_port`

## Requirements
- R1: While reset is asserted and after reset is released, `drdyN` is 1, `busOe` is all zeros and `busData` is all zeros, until a result loads.
- R2: `busOe` is all ones in the cycle after a rising edge that sampled `csN`=0 and `rdN`=0 while a result was held. Otherwise `busOe` and `busData` are all zeros.
- R3: While the bus is driven, `busData` equals the loaded word bit for bit, with bit 15 the MSB and bit 0 the LSB.
- R4: A word sampled with `announce`=1 at edge t loads at edge t+2 if no read is active, and `drdyN` is 0 after that edge.
- R5: `drdyN` is 1 in the two cycles that follow an `announce` edge. When the previous result was never read, `drdyN` therefore goes high for exactly two cycles and then falls.
- R6: A read ends at the first edge that samples `csN` or `rdN` high after a read was active. `drdyN` is 1 after that edge and the bus is released.
- R7: While a read is active, the output register does not change. An update that falls due during the read loads at the edge after the read ends, and `drdyN` falls then.
- R8: A `flush` pulse sampled at an edge makes `drdyN` 1 and `busOe` zero after that edge. It drops any pending word, and read requests are ignored until the next result loads.
- R9: A read request made before any result has loaded since reset leaves the bus undriven and `drdyN` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| announce | input | 1 | Pre-update pulse, two cycles ahead of the load |
| resWord | input | 16 | Result word, valid with `announce` |
| flush | input | 1 | Sync/reset/calibration-done marker; discards stale results |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read |
| drdyN | output | 1 | Active-low data ready |
| busData | output | 16 | Bus data, bit 15 MSB; zero while not driven |
| busOe | output | 16 | Per-bit output enable of the bus |

## Verification
The bench targets three timing cases:
- Result never read: the two-cycle high gap before a load must appear. A design that left `drdyN` low would give the host no edge to see, and a design that loaded early would shorten the gap.
- Update arriving mid-read: the bus must keep the old word until the read ends and then show the new one. A design that loaded immediately would corrupt the word the host is reading.
- Read requests with nothing held: requests made just after reset or after a flush must leave the bus released. A flush with an update pending must produce no ready edge at all, because a careless design would still load the dropped word.

A scoreboard counts the falling edges of `drdyN` against the words announced.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;

  // Strobes handed from the control sequencer to the datapath each cycle.
  typedef struct packed {
    logic captureWord;  // latch announced word into the pending register
    logic loadWord;     // move pending word into the output register
    logic busOn;        // drive the bus this cycle
  } rd_strobe_t;

endpackage

// File: rtl/conv_rd_ctrl.sv
module conv_rd_ctrl
  import conv_rd_pkg::*;
#(
  parameter int WIN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       announce,
  input  logic       flush,
  input  logic       csN,
  input  logic       rdN,
  output rd_strobe_t strobes,
  output logic       drdyN
);

  localparam int CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_IDLE  = '0;

  logic [CNT_W-1:0] winCnt;
  logic             rdActive;
  logic             haveData;

  logic readReq;
  logic loadNow;
  logic readDone;

  // Level sample of the host request at this edge.
  assign readReq  = !csN && !rdN;
  // Load when the window expires, unless a read holds the register or a
  // newer event overrides the pending word.
  assign loadNow  = (winCnt == CNT_LAST) && !rdActive && !announce && !flush;
  assign readDone = rdActive && !readReq;

  // Window countdown.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= CNT_IDLE;
    end else if (flush) begin
      winCnt <= CNT_IDLE;
    end else if (announce) begin
      winCnt <= CNT_START;
    end else if (loadNow) begin
      winCnt <= CNT_IDLE;
    end else if (winCnt > CNT_LAST) begin
      winCnt <= winCnt - CNT_LAST;
    end
  end

  // Bus and data-held state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      haveData <= 1'b0;
    end else if (flush) begin
      rdActive <= 1'b0;
      haveData <= 1'b0;
    end else begin
      rdActive <= readReq && (haveData || loadNow);
      if (loadNow) haveData <= 1'b1;
    end
  end

  // Ready line, highest priority first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drdyN <= 1'b1;
    end else if (flush) begin
      drdyN <= 1'b1;
    end else if (loadNow) begin
      drdyN <= 1'b0;
    end else if (announce || readDone) begin
      drdyN <= 1'b1;
    end
  end

  always_comb begin
    strobes.captureWord = announce && !flush;
    strobes.loadWord    = loadNow;
    strobes.busOn       = rdActive;
  end

endmodule

// File: rtl/conv_rd_datapath.sv
module conv_rd_datapath
  import conv_rd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rd_strobe_t        strobes,
  input  logic [DATA_W-1:0] resWord,
  output logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] busOe
);

  logic [DATA_W-1:0] pendWord;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord <= '0;
      outReg   <= '0;
    end else begin
      if (strobes.captureWord) pendWord <= resWord;
      if (strobes.loadWord)    outReg   <= pendWord;
    end
  end

  // One enable per pad bit; data is gated to zero when not driven.
  for (genvar i = 0; i < DATA_W; i++) begin : g_pad
    assign busOe[i]   = strobes.busOn;
    assign busData[i] = strobes.busOn & outReg[i];
  end

endmodule

// File: rtl/conv_read_port.sv
module conv_read_port
  import conv_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WIN    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              announce,
  input  logic [DATA_W-1:0] resWord,
  input  logic              flush,
  input  logic              csN,
  input  logic              rdN,
  output logic              drdyN,
  output logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] busOe
);

  rd_strobe_t strobes;

  conv_rd_ctrl #(.WIN(WIN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .announce (announce),
    .flush    (flush),
    .csN      (csN),
    .rdN      (rdN),
    .strobes  (strobes),
    .drdyN    (drdyN)
  );

  conv_rd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .resWord (resWord),
    .busData (busData),
    .busOe   (busOe)
  );

endmodule

// File: rtl/conv_read_port_chk.sv
module conv_read_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              announce,
  input logic              flush,
  input logic              csN,
  input logic              rdN,
  input logic              drdyN,
  input logic [DATA_W-1:0] busData,
  input logic [DATA_W-1:0] busOe
);

  // Set one edge after reset release, so $past never reaches before reset.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_bus_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(!csN && !rdN) |-> busOe == '0);

  p_oe_uniform_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busOe == '0) || (busOe == '1));

  p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    armed && busOe[0] && $past(busOe[0]) |-> $stable(busData));

  p_read_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    busOe[0] && (csN || rdN) |=> drdyN);

  p_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    announce && !flush ##1 !flush |=> drdyN);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> drdyN && (busOe == '0));

endmodule

bind conv_read_port conv_read_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .announce (announce),
  .flush    (flush),
  .csN      (csN),
  .rdN      (rdN),
  .drdyN    (drdyN),
  .busData  (busData),
  .busOe    (busOe)
);

// File: tb/sim_conv_read_port.sv
module sim_conv_read_port;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         announce = 1'b0;
  logic [W-1:0] resWord = '0;
  logic         flush = 1'b0;
  logic         csN = 1'b1;
  logic         rdN = 1'b1;
  logic         drdyN;
  logic [W-1:0] busData;
  logic [W-1:0] busOe;

  int checks = 0;
  int fails = 0;
  int falls = 0;
  int pushes = 0;
  bit finished = 1'b0;
  logic [W-1:0] expQ[$];
  logic [W-1:0] expCur = '0;
  logic prevDrdy = 1'b1;

  always #5 clk = ~clk;

  conv_read_port #(.DATA_W(W), .WIN(2)) u0 (
    .clk(clk), .rstN(rstN), .announce(announce), .resWord(resWord),
    .flush(flush), .csN(csN), .rdN(rdN), .drdyN(drdyN),
    .busData(busData), .busOe(busOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  // Scoreboard monitor: each falling edge of drdyN consumes one expected word.
  always @(posedge clk) begin
    #2;
    if (rstN && prevDrdy && !drdyN) begin
      falls++;
      if (expQ.size() == 0) begin
        chk(1'b0, "R4", "drdyN fell with no update queued", 32'(falls), 32'(pushes));
      end else begin
        expCur = expQ.pop_front();
      end
    end
    prevDrdy = drdyN;
  end

  // Announce, then check the two-cycle high window and the load edge.
  task automatic annCheck(input logic [W-1:0] w);
    @(negedge clk);
    announce = 1'b1;
    resWord  = w;
    expQ.push_back(w);
    pushes++;
    settle();
    chk(drdyN === 1'b1, "R5", "drdyN high 1st window cycle", 32'(drdyN), 32'd1);
    @(negedge clk);
    announce = 1'b0;
    settle();
    chk(drdyN === 1'b1, "R5", "drdyN high 2nd window cycle", 32'(drdyN), 32'd1);
    settle();
    chk(drdyN === 1'b0, "R4", "drdyN low after load edge", 32'(drdyN), 32'd0);
    settle();
  endtask

  task automatic doRead(input int len);
    @(negedge clk);
    csN = 1'b0;
    rdN = 1'b0;
    for (int i = 0; i < len; i++) begin
      settle();
      chk(busOe === '1, "R2", "bus enabled during read", 32'(busOe), 32'hFFFF);
      chk(busData === expCur, "R3", "bus word matches scoreboard", 32'(busData), 32'(expCur));
    end
    @(negedge clk);
    rdN = 1'b1;
    settle();
    chk(busOe === '0, "R6", "bus released after read", 32'(busOe), 32'd0);
    chk(drdyN === 1'b1, "R6", "drdyN high after read", 32'(drdyN), 32'd1);
    @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic tryReadOff(input string req);
    @(negedge clk);
    csN = 1'b0;
    rdN = 1'b0;
    settle();
    chk(busOe === '0, req, "bus stays off with nothing held", 32'(busOe), 32'd0);
    chk(drdyN === 1'b1, req, "drdyN stays high with nothing held", 32'(drdyN), 32'd1);
    @(negedge clk);
    csN = 1'b1;
    rdN = 1'b1;
    settle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'(checks), 32'd0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(drdyN === 1'b1, "R1", "drdyN during reset", 32'(drdyN), 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    settle();
    chk(drdyN === 1'b1, "R1", "drdyN after reset", 32'(drdyN), 32'd1);
    chk(busOe === '0, "R1", "bus off after reset", 32'(busOe), 32'd0);
    chk(busData === '0, "R1", "bus data zero after reset", 32'(busData), 32'd0);

    // R9: read before any result
    tryReadOff("R9");

    // R3: bit order, MSB and LSB set
    annCheck(16'h8001);
    doRead(3);
    // read completed, new update (drdy already high)
    annCheck(16'h1234);
    // not read: two-cycle high gap then fall (R5)
    annCheck(16'hBEEF);
    doRead(1);
    for (int k = 1; k <= 3; k++) begin
      annCheck(16'h0F0F ^ 16'(k * 16'h1111));
      doRead(k);
    end

    // R7: update falls due while a read is active
    @(negedge clk);
    csN = 1'b0;
    rdN = 1'b0;
    settle();
    chk(busData === expCur, "R7", "old word on bus before update", 32'(busData), 32'(expCur));
    @(negedge clk);
    announce = 1'b1;
    resWord  = 16'hA5C3;
    expQ.push_back(16'hA5C3);
    pushes++;
    settle();
    @(negedge clk);
    announce = 1'b0;
    settle();
    settle();
    chk(drdyN === 1'b1, "R7", "no load while read active", 32'(drdyN), 32'd1);
    chk(busData === expCur, "R7", "bus word held during read", 32'(busData), 32'(expCur));
    settle();
    chk(busData === expCur, "R7", "bus word still held", 32'(busData), 32'(expCur));
    @(negedge clk);
    csN = 1'b1;
    rdN = 1'b1;
    settle();
    chk(busOe === '0, "R6", "bus released at read end", 32'(busOe), 32'd0);
    chk(drdyN === 1'b1, "R7", "drdyN high at read end", 32'(drdyN), 32'd1);
    settle();
    chk(drdyN === 1'b0, "R7", "deferred word loaded next edge", 32'(drdyN), 32'd0);
    doRead(2);
    chk(busData === '0, "R2", "bus data zero when released", 32'(busData), 32'd0);

    // R8: flush after a loaded result
    annCheck(16'h7E11);
    @(negedge clk);
    flush = 1'b1;
    settle();
    chk(drdyN === 1'b1, "R8", "drdyN high after flush", 32'(drdyN), 32'd1);
    chk(busOe === '0, "R8", "bus off after flush", 32'(busOe), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    tryReadOff("R8");
    annCheck(16'h3C96);
    doRead(1);

    // R8: flush drops a pending word
    @(negedge clk);
    announce = 1'b1;
    resWord  = 16'hDEAD;
    @(negedge clk);
    announce = 1'b0;
    flush    = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 4; i++) begin
      settle();
      chk(drdyN === 1'b1, "R8", "dropped word never loads", 32'(drdyN), 32'd1);
    end
    tryReadOff("R8");
    annCheck(16'h0240);
    doRead(2);

    repeat (3) settle();
    chk(expQ.size() == 0, "R4", "scoreboard empty", 32'(expQ.size()), 32'd0);
    chk(falls == pushes, "R4", "one drdyN fall per update", 32'(falls), 32'(pushes));
    summary();
  end

endmodule